// File: doc/BRIEF.md
# Signal-Strength Conversion Controller

This block decides when a received-signal-strength sample is taken and holds the result for software. While the receiver is enabled, it watches a carrier-detect input. A software override bit can stand in for that input. The carrier must stay present without a break for longer than a programmable qualification window, `WINDOW_CYC` clock cycles. The default of 650 cycles is 50 µs at 13 MHz. When the window has passed, the block sends a one-cycle start pulse to an external 5-bit converter.

When the converter returns its done pulse, the sample and a valid flag are latched into an 8-bit status byte. The block then sits in a halted state and ignores the carrier and the converter. It leaves that state only when receive mode is dropped and raised again.

Noise-floor measurement on a quiet channel uses the override bit in place of a real carrier. Software sets the override bit, waits for the valid flag, reads the byte, clears the override and disables the receiver.

Top module: `rssi_ctrl`

## Requirements
- R1: After reset, `rssi_status` is 0x00 and `adc_start` is low.
- R2: With `rx_en` high, `adc_start` rises in the cycle after the (WINDOW_CYC+1)-th consecutive rising edge at which the carrier (`carrier_det` OR `cd_force`) was sampled high. It is never high earlier.
- R3: If the carrier is sampled low at any edge before the start, the persistence count begins again from zero.
- R4: `cd_force` high qualifies exactly as a detected carrier does, with `carrier_det` held low.
- R5: `adc_start` is high for exactly one cycle. The result is loaded only on an `adc_done` that arrives after that pulse. A done pulse during qualification leaves `rssi_status` at 0x00.
- R6: On a loaded result, the next cycle shows `rssi_status[4:0]` = the `adc_sample` value, `rssi_status[5]` = 1, and `rssi_status[7:6]` = 0.
- R7: Once a result is held, no further `adc_start` occurs while `rx_en` stays high, even with the carrier present. Later done pulses do not alter `rssi_status`.
- R8: `rx_en` sampled low clears `rssi_status` to 0x00 in the next cycle. After `rx_en` returns high, a new conversion again needs a full qualification window.
- R9: `rx_en` going low during qualification or while a conversion is outstanding abandons it. A done pulse that arrives afterwards is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive mode enable |
| carrier_det | input | 1 | On-channel carrier detected |
| cd_force | input | 1 | Software override acting as a detected carrier |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion complete strobe |
| adc_sample | input | 5 | Converted sample, valid with `adc_done` |
| rssi_status | output | 8 | Bit 5 valid, bits 4:0 sample, bits 7:6 zero |

## Verification
The bench probes the qualification window at its exact edge. A carrier held for WINDOW_CYC edges must not start a conversion, and one more edge must. An off-by-one counter would start one cycle early or one cycle late. A carrier gap one edge before expiry checks that the count restarts. A design that only pauses the count would start far too soon. After a result is held, the carrier is left on for twice the window and stray done pulses are sent. A machine that re-arms would pulse start again or overwrite the sample. Receive mode is also dropped while a conversion is outstanding. An unaborted conversion would then latch the late sample.

// File: rtl/rssi_ctrl.sv
module rssi_ctrl #(
  parameter int WINDOW_CYC = 650,
  parameter int SAMPLE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                carrier_det,
  input  logic                cd_force,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [SAMPLE_W-1:0] adc_sample,
  output logic [7:0]          rssi_status
);
  localparam int CW = $clog2(WINDOW_CYC + 1);

  typedef enum logic [1:0] {S_ARM, S_CONV, S_HALT} state_t;

  state_t              state;
  logic [CW-1:0]       run_cnt;
  logic [SAMPLE_W-1:0] sample_q;
  logic                valid_q;
  logic                cd;

  assign cd          = carrier_det | cd_force;
  assign rssi_status = {2'b00, valid_q, sample_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_ARM;
      run_cnt   <= '0;
      sample_q  <= '0;
      valid_q   <= 1'b0;
      adc_start <= 1'b0;
    end else if (!rx_en) begin
      state     <= S_ARM;
      run_cnt   <= '0;
      sample_q  <= '0;
      valid_q   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      case (state)
        S_ARM: begin
          if (!cd)
            run_cnt <= '0;
          else if (run_cnt == CW'(WINDOW_CYC)) begin
            run_cnt   <= '0;
            adc_start <= 1'b1;
            state     <= S_CONV;
          end else
            run_cnt <= run_cnt + 1'b1;
        end
        S_CONV: begin
          if (adc_done && !adc_start) begin
            sample_q <= adc_sample;
            valid_q  <= 1'b1;
            state    <= S_HALT;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rssi_ctrl_chk.sv
module rssi_ctrl_chk #(
  parameter int WINDOW_CYC = 650,
  parameter int SAMPLE_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en,
  input logic                carrier_det,
  input logic                cd_force,
  input logic                adc_start,
  input logic                adc_done,
  input logic [SAMPLE_W-1:0] adc_sample,
  input logic [7:0]          rssi_status
);
  localparam int RW = $clog2(WINDOW_CYC + 2);
  logic [RW-1:0] cd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cd_run <= '0;
    else if (!(rx_en && (carrier_det || cd_force)))
      cd_run <= '0;
    else if (cd_run != RW'(WINDOW_CYC + 1))
      cd_run <= cd_run + 1'b1;
  end

  assert_window_met_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> cd_run == RW'(WINDOW_CYC + 1));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_load_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rssi_status[5]) |-> ($past(adc_done) && rssi_status[4:0] == $past(adc_sample)));

  assert_top_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_status[7:6] == 2'b00);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_status[5] && rx_en) |=> ($stable(rssi_status) && !adc_start));

  assert_rx_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rssi_status == 8'h00 && !adc_start));
endmodule

bind rssi_ctrl rssi_ctrl_chk #(.WINDOW_CYC(WINDOW_CYC), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .carrier_det(carrier_det),
  .cd_force(cd_force), .adc_start(adc_start), .adc_done(adc_done),
  .adc_sample(adc_sample), .rssi_status(rssi_status));

// File: tb/test_rssi_ctrl.sv
module test_rssi_ctrl;
  localparam int W = 650;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       carrier_det = 1'b0;
  logic       cd_force = 1'b0;
  logic       adc_done = 1'b0;
  logic [4:0] adc_sample = 5'd0;
  logic       adc_start;
  logic [7:0] rssi_status;

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  rssi_ctrl #(.WINDOW_CYC(W), .SAMPLE_W(5)) i_rssi_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .carrier_det(carrier_det),
    .cd_force(cd_force), .adc_start(adc_start), .adc_done(adc_done),
    .adc_sample(adc_sample), .rssi_status(rssi_status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet_for(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (adc_start) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic do_conv(input logic [4:0] v, input string req);
    adc_done = 1'b1; adc_sample = v;
    step(1);
    adc_done = 1'b0;
    chk(rssi_status == {3'b001, v}, req, rssi_status, {3'b001, v});
  endtask

  task automatic rx_restart();
    rx_en = 1'b0; carrier_det = 1'b0; cd_force = 1'b0;
    step(1);
    chk(rssi_status == 8'h00, "R8 clear", rssi_status, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_reset();
    step(2);
    chk(rssi_status == 8'h00 && !adc_start, "R1 reset", rssi_status, 0);
    rst_n = 1'b1;
    step(1);
    chk(rssi_status == 8'h00 && !adc_start, "R1 after release", rssi_status, 0);
  endtask

  task automatic t_normal();
    rx_en = 1'b1; carrier_det = 1'b1;
    step(W / 2);
    adc_done = 1'b1; adc_sample = 5'd9;
    step(1);
    adc_done = 1'b0;
    chk(rssi_status == 8'h00, "R5 early done ignored", rssi_status, 0);
    quiet_for(W - W / 2 - 1, "R2 no early start");
    step(1);
    chk(adc_start == 1'b1, "R2 start at window", adc_start, 1);
    step(1);
    chk(adc_start == 1'b0, "R5 single pulse", adc_start, 0);
    do_conv(5'd21, "R6 result format");
  endtask

  task automatic t_halt();
    quiet_for(2 * W, "R7 no restart in halt");
    adc_done = 1'b1; adc_sample = 5'd3;
    step(1);
    adc_done = 1'b0;
    chk(rssi_status == 8'h35, "R7 result held", rssi_status, 8'h35);
  endtask

  task automatic t_gap();
    rx_restart();
    carrier_det = 1'b1;
    quiet_for(W, "R3 pre-gap");
    carrier_det = 1'b0;
    step(1);
    carrier_det = 1'b1;
    quiet_for(W, "R3 count restarted");
    step(1);
    chk(adc_start == 1'b1, "R3 start after full window", adc_start, 1);
    step(1);
    do_conv(5'd31, "R6 max value");
  endtask

  task automatic t_force();
    rx_restart();
    cd_force = 1'b1;
    quiet_for(W, "R4 force window");
    step(1);
    chk(adc_start == 1'b1, "R4 force starts", adc_start, 1);
    step(1);
    do_conv(5'd0, "R4 zero sample valid");
    cd_force = 1'b0;
  endtask

  task automatic t_rearm();
    rx_restart();
    carrier_det = 1'b1;
    quiet_for(W, "R8 full window again");
    step(1);
    chk(adc_start == 1'b1, "R8 restart converts", adc_start, 1);
    step(1);
    do_conv(5'd12, "R8 new result");
  endtask

  task automatic t_abort();
    rx_restart();
    carrier_det = 1'b1;
    step(W + 1);
    chk(adc_start == 1'b1, "R9 start before abort", adc_start, 1);
    rx_en = 1'b0;
    step(1);
    rx_en = 1'b1; carrier_det = 1'b0;
    adc_done = 1'b1; adc_sample = 5'd7;
    step(1);
    adc_done = 1'b0;
    chk(rssi_status == 8'h00, "R9 late done ignored", rssi_status, 0);
    quiet_for(4, "R9 no start without carrier");
  endtask

  initial begin
    t_reset();
    t_normal();
    t_halt();
    t_gap();
    t_force();
    t_rearm();
    t_abort();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule